// File: doc/BRIEF.md
# Switch Input Port Header Stripper

This block stands at one input port of a packet switch. Every packet arriving on the port starts with a data character that names the output port it wants. The block uses that first character to set the route and does not pass it on. It then raises a request toward the crossbar that carries the chosen port number. It holds back the rest of the packet until the crossbar pulls its active-low grant line low. After the grant, it passes the cargo characters to the crossbar one by one, each tagged with the destination port, and it marks that port as occupied. The packet ends with an end marker, which is either a normal end or an error end. The marker is forwarded like cargo. One cycle later the request and the occupied mark are released, and the next character is read as a new header.

Each character is a data word plus one flag bit above it: flag 0 marks a data character and flag 1 marks a control character. The upstream side is flow-controlled by a ready output. Ready is low while the request waits for a grant and whenever the grant is withdrawn, so no character is lost. A header that names a port outside the configured port count causes the whole packet, up to and including its end marker, to be discarded.

Top module: `pkt_entrance`

## Requirements
- R1: After reset, `in_ready` is 1 and `want`, `occupied` and `out_valid` are all 0.
- R2: A data character (flag 0) accepted as a header whose value is below NUM_PORTS is not forwarded. In the next cycle `want` is 1, `want_port` equals that value and `out_valid` is 0.
- R3: While `want` is 1 and no grant has yet been seen, `in_ready` is 0, `occupied` is all zeros and `want_port` stays stable.
- R4: Once `grant_n` is 0, `in_ready` is 1. Each accepted cargo character appears on `out_char` one cycle later, with `out_valid` 1, its flag bit unchanged and `out_port` equal to the destination.
- R5: From the cycle after the grant until the packet is released, `occupied` is one-hot with the bit of the destination port set. At all other times it is zero.
- R6: If `grant_n` goes to 1 during cargo transfer, `in_ready` drops to 0 in the same cycle and no character is accepted or forwarded. The held character is forwarded after the grant returns.
- R7: A control character (flag 1) with data value 0 (normal end) or 1 (error end) is forwarded as the last character. `want` and `occupied` are still set while it is on the output and are 0 in the following cycle. The next accepted character is then decoded as a header.
- R8: A header value of NUM_PORTS or more leaves `want` at 0 and `in_ready` at 1. Every character up to and including the next end marker is discarded without output, even if it looks like a valid header.
- R9: A control character arriving where a header is expected is consumed and ignored: no request and no output.
- R10: Control characters with data values other than 0 and 1 that arrive during cargo are forwarded and do not end the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input character is present |
| in_char | input | DATA_W+1 | Input character; the top bit is the control flag |
| in_ready | output | 1 | Block accepts the input character this cycle |
| want | output | 1 | Request for an output port toward the crossbar |
| want_port | output | PORT_W | Requested destination port |
| grant_n | input | 1 | Grant from the crossbar, active low |
| occupied | output | NUM_PORTS | One-hot mark of the port in use |
| out_valid | output | 1 | Output cargo character is present |
| out_char | output | DATA_W+1 | Forwarded cargo character with its flag |
| out_port | output | PORT_W | Destination tag of the forwarded character |

## Verification
The hardest situation to reach from the ports is a withdrawn grant in the middle of a packet while a character is already waiting at the input. The stimulus keeps that character on the input while the grant line is high for several cycles. It checks that ready stays low and that nothing new appears on the output. It then returns the grant and checks that the same character comes out once. A second hard case is a rejected header whose discarded cargo contains a value that would be a legal port. Sending that value proves that discard mode does not fall back to header decoding before the end marker.

// File: rtl/pkt_entrance_pkg.sv
package pkt_entrance_pkg;
   typedef enum logic [2:0] {
      ST_HDR  = 3'd0,
      ST_WAIT = 3'd1,
      ST_MOVE = 3'd2,
      ST_LAST = 3'd3,
      ST_DROP = 3'd4
   } entr_state_t;

   localparam int unsigned CODE_END_OK  = 0;
   localparam int unsigned CODE_END_ERR = 1;
endpackage

// File: rtl/pkt_entr_classify.sv
module pkt_entr_classify #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned PORT_W    = 2
) (
   input  logic [DATA_W:0]   ch,
   output logic              is_ctrl,
   output logic              is_end,
   output logic              hdr_ok,
   output logic [PORT_W-1:0] hdr_port
);
   import pkt_entrance_pkg::*;

   logic [DATA_W-1:0] word;

   assign word     = ch[DATA_W-1:0];
   assign is_ctrl  = ch[DATA_W];
   assign is_end   = ch[DATA_W] &&
                     ((word == DATA_W'(CODE_END_OK)) || (word == DATA_W'(CODE_END_ERR)));
   assign hdr_port = word[PORT_W-1:0];

   generate
      if (NUM_PORTS == (1 << DATA_W)) begin : g_full_range
         assign hdr_ok = !ch[DATA_W];
      end else begin : g_bounded
         assign hdr_ok = !ch[DATA_W] && (word < DATA_W'(NUM_PORTS));
      end
   endgenerate
endmodule

// File: rtl/pkt_entr_fsm.sv
module pkt_entr_fsm #(
   parameter int unsigned PORT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              is_ctrl,
   input  logic              is_end,
   input  logic              hdr_ok,
   input  logic [PORT_W-1:0] hdr_port,
   input  logic              grant_n,
   output logic              in_ready,
   output logic              fwd,
   output logic              want,
   output logic              active,
   output logic [PORT_W-1:0] dest
);
   import pkt_entrance_pkg::*;

   entr_state_t st, st_nx;
   logic        load;

   always_comb begin
      st_nx    = st;
      in_ready = 1'b0;
      fwd      = 1'b0;
      load     = 1'b0;
      case (st)
         ST_HDR: begin
            in_ready = 1'b1;
            if (in_valid && !is_ctrl) begin
               if (hdr_ok) begin
                  st_nx = ST_WAIT;
                  load  = 1'b1;
               end else begin
                  st_nx = ST_DROP;
               end
            end
         end
         ST_WAIT: begin
            if (!grant_n) st_nx = ST_MOVE;
         end
         ST_MOVE: begin
            in_ready = !grant_n;
            if (in_valid && !grant_n) begin
               fwd = 1'b1;
               if (is_end) st_nx = ST_LAST;
            end
         end
         ST_LAST: begin
            st_nx = ST_HDR;
         end
         ST_DROP: begin
            in_ready = 1'b1;
            if (in_valid && is_end) st_nx = ST_HDR;
         end
         default: st_nx = ST_HDR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_HDR;
         dest <= '0;
      end else begin
         st <= st_nx;
         if (load) dest <= hdr_port;
      end
   end

   assign want   = (st == ST_WAIT) || (st == ST_MOVE) || (st == ST_LAST);
   assign active = (st == ST_MOVE) || (st == ST_LAST);
endmodule

// File: rtl/pkt_entr_occupy.sv
module pkt_entr_occupy #(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned PORT_W    = 2
) (
   input  logic                 active,
   input  logic [PORT_W-1:0]    dest,
   output logic [NUM_PORTS-1:0] occupied
);
   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         assign occupied[p] = active && (dest == PORT_W'(p));
      end
   endgenerate
endmodule

// File: rtl/pkt_entr_outreg.sv
module pkt_entr_outreg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PORT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd,
   input  logic [DATA_W:0]   ch,
   input  logic [PORT_W-1:0] dest,
   output logic              out_valid,
   output logic [DATA_W:0]   out_char,
   output logic [PORT_W-1:0] out_port
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_char  <= '0;
         out_port  <= '0;
      end else begin
         out_valid <= fwd;
         if (fwd) begin
            out_char <= ch;
            out_port <= dest;
         end
      end
   end
endmodule

// File: rtl/pkt_entrance.sv
module pkt_entrance #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_PORTS = 4,
   localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [DATA_W:0]      in_char,
   output logic                 in_ready,
   output logic                 want,
   output logic [PORT_W-1:0]    want_port,
   input  logic                 grant_n,
   output logic [NUM_PORTS-1:0] occupied,
   output logic                 out_valid,
   output logic [DATA_W:0]      out_char,
   output logic [PORT_W-1:0]    out_port
);
   generate
      if (NUM_PORTS < 2) begin : g_chk_ports
         $error("pkt_entrance: NUM_PORTS must be at least 2");
      end
      if (DATA_W < PORT_W || NUM_PORTS > (1 << DATA_W)) begin : g_chk_width
         $error("pkt_entrance: DATA_W too narrow to address all ports");
      end
   endgenerate

   logic              is_ctrl, is_end, hdr_ok, fwd, active;
   logic [PORT_W-1:0] hdr_port, dest;

   pkt_entr_classify #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_classify (
      .ch       (in_char),
      .is_ctrl  (is_ctrl),
      .is_end   (is_end),
      .hdr_ok   (hdr_ok),
      .hdr_port (hdr_port)
   );

   pkt_entr_fsm #(.PORT_W(PORT_W)) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .is_ctrl  (is_ctrl),
      .is_end   (is_end),
      .hdr_ok   (hdr_ok),
      .hdr_port (hdr_port),
      .grant_n  (grant_n),
      .in_ready (in_ready),
      .fwd      (fwd),
      .want     (want),
      .active   (active),
      .dest     (dest)
   );

   pkt_entr_occupy #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_occupy (
      .active   (active),
      .dest     (dest),
      .occupied (occupied)
   );

   pkt_entr_outreg #(.DATA_W(DATA_W), .PORT_W(PORT_W)) i_outreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .fwd       (fwd),
      .ch        (in_char),
      .dest      (dest),
      .out_valid (out_valid),
      .out_char  (out_char),
      .out_port  (out_port)
   );

   assign want_port = dest;
endmodule

// File: rtl/pkt_entrance_chk.sv
module pkt_entrance_chk #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned PORT_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_ready,
   input logic                 want,
   input logic [PORT_W-1:0]    want_port,
   input logic                 grant_n,
   input logic [NUM_PORTS-1:0] occupied,
   input logic                 out_valid,
   input logic [DATA_W:0]      out_char,
   input logic [PORT_W-1:0]    out_port
);
   logic out_is_end;
   assign out_is_end = out_char[DATA_W] &&
                       (out_char[DATA_W-1:0] == DATA_W'(0) || out_char[DATA_W-1:0] == DATA_W'(1));

   AST_WAIT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (want && occupied == '0) |-> !in_ready); // R3
   AST_PORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (want && $past(want)) |-> $stable(want_port)); // R3
   AST_OCC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(occupied)); // R5
   AST_OCC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (occupied != '0) |-> (want && occupied[want_port])); // R5
   AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (occupied != '0 && grant_n) |-> !in_ready); // R6
   AST_OUT_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (want && out_port == want_port && occupied != '0)); // R4
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_is_end) |=> (!want && occupied == '0)); // R7
endmodule

bind pkt_entrance pkt_entrance_chk #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .want      (want),
   .want_port (want_port),
   .grant_n   (grant_n),
   .occupied  (occupied),
   .out_valid (out_valid),
   .out_char  (out_char),
   .out_port  (out_port)
);

// File: tb/test_pkt_entrance.sv
module test_pkt_entrance;
   localparam int unsigned DATA_W    = 8;
   localparam int unsigned NUM_PORTS = 4;
   localparam int unsigned PORT_W    = 2;
   localparam time         CLK_PER   = 10ns;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic [DATA_W:0]      in_char = '0;
   logic                 in_ready;
   logic                 want;
   logic [PORT_W-1:0]    want_port;
   logic                 grant_n = 1'b1;
   logic [NUM_PORTS-1:0] occupied;
   logic                 out_valid;
   logic [DATA_W:0]      out_char;
   logic [PORT_W-1:0]    out_port;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PER/2) clk = ~clk;

   pkt_entrance #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) i_pkt_entrance (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char), .in_ready(in_ready),
      .want(want), .want_port(want_port), .grant_n(grant_n), .occupied(occupied),
      .out_valid(out_valid), .out_char(out_char), .out_port(out_port)
   );

   function automatic logic [DATA_W:0] dch(input logic [DATA_W-1:0] v);
      return {1'b0, v};
   endfunction
   function automatic logic [DATA_W:0] cch(input logic [DATA_W-1:0] v);
      return {1'b1, v};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic nx();
      @(negedge clk);
   endtask

   task automatic drv(input logic v, input logic [DATA_W:0] c);
      in_valid = v;
      in_char  = c;
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   task automatic t_reset();
      chk("R1 ready", 32'(in_ready), 1);
      chk("R1 want", 32'(want), 0);
      chk("R1 occupied", 32'(occupied), 0);
      chk("R1 out_valid", 32'(out_valid), 0);
   endtask

   task automatic t_basic();
      nx(); chk("R2 ready idle", 32'(in_ready), 1); drv(1, dch(8'd2));
      nx(); drv(0, '0);
      chk("R2 want", 32'(want), 1); chk("R2 port", 32'(want_port), 2);
      chk("R2 header not forwarded", 32'(out_valid), 0); chk("R3 ready low", 32'(in_ready), 0);
      nx(); chk("R3 still want", 32'(want), 1); chk("R3 no occupy", 32'(occupied), 0);
      chk("R3 ready low", 32'(in_ready), 0);
      grant_n = 1'b0;
      nx(); chk("R5 occupied", 32'(occupied), 32'h4); chk("R4 ready", 32'(in_ready), 1);
      drv(1, dch(8'hA1));
      nx(); chk("R4 out_valid", 32'(out_valid), 1); chk("R4 out_char", 32'(out_char), 32'(dch(8'hA1)));
      chk("R4 out_port", 32'(out_port), 2);
      drv(1, cch(8'd0));
      nx(); drv(0, '0);
      chk("R7 end out", 32'(out_char), 32'(cch(8'd0))); chk("R7 end valid", 32'(out_valid), 1);
      chk("R7 want held", 32'(want), 1); chk("R7 ready low", 32'(in_ready), 0);
      nx(); chk("R7 want released", 32'(want), 0); chk("R7 occupied released", 32'(occupied), 0);
      chk("R7 out idle", 32'(out_valid), 0); chk("R7 ready back", 32'(in_ready), 1);
      grant_n = 1'b1;
   endtask

   task automatic t_stall();
      nx(); drv(1, dch(8'd0));
      nx(); drv(0, '0); chk("R2 port0", 32'(want_port), 0); grant_n = 1'b0;
      nx(); drv(1, dch(8'hB1));
      nx(); chk("R4 B1 out", 32'(out_char), 32'(dch(8'hB1)));
      grant_n = 1'b1; drv(1, dch(8'hB2)); #1;
      chk("R6 ready drops", 32'(in_ready), 0);
      nx(); chk("R6 no output", 32'(out_valid), 0); chk("R6 still occupied", 32'(occupied), 1);
      nx(); chk("R6 no output 2", 32'(out_valid), 0);
      grant_n = 1'b0; #1; chk("R6 ready returns", 32'(in_ready), 1);
      nx(); chk("R6 held char out", 32'(out_char), 32'(dch(8'hB2))); chk("R6 out valid", 32'(out_valid), 1);
      drv(1, cch(8'd0));
      nx(); drv(0, '0);
      nx(); chk("R7 release after stall", 32'(want), 0);
      grant_n = 1'b1;
   endtask

   task automatic t_drop_and_ctrl();
      nx(); drv(1, dch(8'd7));
      nx(); chk("R8 no want", 32'(want), 0); chk("R8 ready", 32'(in_ready), 1);
      chk("R8 no out", 32'(out_valid), 0);
      drv(1, dch(8'd1));
      nx(); chk("R8 cargo not header", 32'(want), 0); chk("R8 no out cargo", 32'(out_valid), 0);
      drv(1, cch(8'd0));
      nx(); chk("R8 end discarded", 32'(out_valid), 0); chk("R8 still no want", 32'(want), 0);
      drv(1, dch(8'd3));
      nx(); drv(0, '0);
      chk("R8 next header", 32'(want), 1); chk("R2 top port", 32'(want_port), 3);
      grant_n = 1'b0;
      nx(); chk("R5 port3 occupied", 32'(occupied), 32'h8); drv(1, cch(8'd5));
      nx(); chk("R10 ctrl forwarded", 32'(out_char), 32'(cch(8'd5)));
      chk("R10 packet continues", 32'(want), 1);
      drv(1, cch(8'd1));
      nx(); drv(0, '0); chk("R7 error end out", 32'(out_char), 32'(cch(8'd1)));
      chk("R7 error end tag", 32'(out_port), 3);
      nx(); chk("R7 error end release", 32'(want), 0);
      grant_n = 1'b1;
   endtask

   task automatic t_stray();
      nx(); drv(1, cch(8'd0));
      nx(); chk("R9 no want", 32'(want), 0); chk("R9 no out", 32'(out_valid), 0);
      chk("R9 ready", 32'(in_ready), 1);
      drv(1, dch(8'd1));
      nx(); drv(0, '0); chk("R9 header after stray", 32'(want_port), 1);
      chk("R9 want", 32'(want), 1);
      grant_n = 1'b0;
      nx(); drv(1, cch(8'd0));
      nx(); drv(0, '0); chk("R7 empty cargo end", 32'(out_char), 32'(cch(8'd0)));
      chk("R4 empty tag", 32'(out_port), 1);
      nx(); chk("R7 empty release", 32'(occupied), 0);
      grant_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      nx();
      t_reset();
      t_basic();
      t_stall();
      t_drop_and_ctrl();
      t_stray();
      nx();
      report();
      $finish;
   end
endmodule